// File: doc/BRIEF.md
# Serial Receiver Standby and Wake-Up Control

This block decides whether a serial receiver hands its received characters and idle-line events on to software, or holds them back while it sleeps through traffic meant for other nodes. Software parks the receiver by writing its standby bit to 1. From then on the block watches for one of two hardware wake conditions and clears the bit by itself when that condition appears.

- **Idle-line wake** (select 0): the receiver wakes on an idle-line event.
- **Address-mark wake** (select 1): the receiver wakes on a character whose top data bit is 1.

The block keeps the data-ready and idle flags. While standby is set it stops characters and idle events from setting those flags. It forms the receive interrupt and the idle interrupt from the flags and their enables. It also reports whether the receive pin belongs to the receiver or has gone back to general-purpose use.

Bit sampling, framing and shifting are done upstream. The upstream receiver gives this block:

- a one-cycle character strobe, together with the character's top data bit;
- a one-cycle idle-line strobe.

Top module: `rx_wake_standby`

## Requirements
- R1: After reset, standby, dataReady, idleFlag, rxIrq and idleIrq are all 0.
- R2: With rxEnable at 1, a cycle with standbyWr at 1 loads standbyWrVal into standby at that clock edge, so software can enter standby by writing 1 and leave it by writing 0.
- R3: With wakeSel at 0 and standby at 1, an idleStrobe clears standby at that edge and does not set idleFlag. A charStrobe in a later cycle sets dataReady normally.
- R4: With wakeSel at 1 and standby at 1, a charStrobe with charMsb at 1 clears standby and sets dataReady at the same edge.
- R5: While standby is 1, a character that does not wake the receiver leaves dataReady unchanged. Non-waking characters are any character when wakeSel is 0, and a character with charMsb at 0 when wakeSel is 1. An idleStrobe with wakeSel at 1 leaves both idleFlag and standby unchanged.
- R6: Outside standby, charStrobe sets dataReady and idleStrobe sets idleFlag at the next edge. readyClr clears dataReady and idleClr clears idleFlag. When a set and a clear of the same flag arrive in one cycle, the set wins.
- R7: rxIrq equals rxIntEn AND dataReady, and idleIrq equals idleIntEn AND idleFlag, in the same cycle and without extra delay.
- R8: While rxEnable is 0, a write of 1 to standby has no effect. In that state standby, dataReady and idleFlag go to 0 at the next edge, and the strobes are ignored.
- R9: rxPinOwn is 1 only when rxEnable is 1 and loopMode is 0. In every other case the receive pin is released to general-purpose use.
- R10: When a standby write and a wake condition fall in the same cycle, the written value wins. A character that meets the address-mark wake condition still sets dataReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver on |
| loopMode | input | 1 | Internal loop operation; releases the receive pin |
| standbyWr | input | 1 | One-cycle write strobe for the standby bit |
| standbyWrVal | input | 1 | Value written to the standby bit |
| wakeSel | input | 1 | Wake method: 0 idle line, 1 address mark |
| idleStrobe | input | 1 | One-cycle idle-line detect |
| charStrobe | input | 1 | One-cycle character received |
| charMsb | input | 1 | Top data bit of the received character |
| readyClr | input | 1 | Clear data-ready flag |
| idleClr | input | 1 | Clear idle flag |
| rxIntEn | input | 1 | Receive interrupt enable |
| idleIntEn | input | 1 | Idle interrupt enable |
| standby | output | 1 | Standby status |
| dataReady | output | 1 | Gated data-ready flag |
| idleFlag | output | 1 | Gated idle flag |
| rxIrq | output | 1 | Receive interrupt |
| idleIrq | output | 1 | Idle interrupt |
| rxPinOwn | output | 1 | Receive pin owned by the receiver |

## Verification
A wrong standby state shows up one edge after the next strobe. Two failure directions are possible:

- A receiver stuck asleep leaves dataReady at 0 after a character that should have been delivered.
- A receiver that wakes too early raises dataReady or idleFlag, and its interrupt, on traffic that should have been hidden.

A wrong wake decode shows as standby still at 1, or as an idle flag set by the waking idle event, one cycle after the wake condition. The sweep starts every combination of enable, wake method, starting standby and strobe pattern from a flushed state. Any such fault is therefore caught within a single stimulus cycle.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int FLAG_COUNT = 2;
  localparam int READY_IDX  = 0;
  localparam int IDLE_IDX   = 1;

  typedef struct packed {
    logic setReady;
    logic setIdle;
    logic flush;
  } rxwStrobes_t;
endpackage

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
  import rxw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic        standbyWr,
  input  logic        standbyWrVal,
  input  logic        wakeSel,
  input  logic        idleStrobe,
  input  logic        charStrobe,
  input  logic        charMsb,
  output logic        standby,
  output rxwStrobes_t strobes
);
  logic addrMark;
  logic wakeHit;

  assign addrMark = charStrobe && charMsb;
  assign wakeHit  = standby && (wakeSel ? addrMark : idleStrobe);

  // Standby bit: disable forces 0, a write beats a wake (R10), a wake clears it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           standby <= 1'b0;
    else if (!rxEnable)  standby <= 1'b0;
    else if (standbyWr)  standby <= standbyWrVal;
    else if (wakeHit)    standby <= 1'b0;
  end

  always_comb begin
    strobes.flush    = !rxEnable;
    // A waking address-marked character is delivered as it wakes the receiver.
    strobes.setReady = rxEnable && charStrobe && (!standby || (wakeSel && charMsb));
    // The waking idle event is consumed by the wake and never raises the flag.
    strobes.setIdle  = rxEnable && idleStrobe && !standby;
  end
endmodule

// File: rtl/rxw_flags.sv
module rxw_flags
  import rxw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  rxwStrobes_t strobes,
  input  logic        readyClr,
  input  logic        idleClr,
  input  logic        rxIntEn,
  input  logic        idleIntEn,
  output logic        dataReady,
  output logic        idleFlag,
  output logic        rxIrq,
  output logic        idleIrq
);
  logic [FLAG_COUNT-1:0] setVec;
  logic [FLAG_COUNT-1:0] clrVec;
  logic [FLAG_COUNT-1:0] enVec;
  logic [FLAG_COUNT-1:0] flagQ;
  logic [FLAG_COUNT-1:0] irqVec;

  always_comb begin
    setVec[READY_IDX] = strobes.setReady;
    setVec[IDLE_IDX]  = strobes.setIdle;
    clrVec[READY_IDX] = readyClr;
    clrVec[IDLE_IDX]  = idleClr;
    enVec[READY_IDX]  = rxIntEn;
    enVec[IDLE_IDX]   = idleIntEn;
  end

  for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              flagQ[g] <= 1'b0;
      else if (strobes.flush) flagQ[g] <= 1'b0;
      else if (setVec[g])     flagQ[g] <= 1'b1;
      else if (clrVec[g])     flagQ[g] <= 1'b0;
    end
    assign irqVec[g] = enVec[g] && flagQ[g];
  end

  assign dataReady = flagQ[READY_IDX];
  assign idleFlag  = flagQ[IDLE_IDX];
  assign rxIrq     = irqVec[READY_IDX];
  assign idleIrq   = irqVec[IDLE_IDX];
endmodule

// File: rtl/rx_wake_standby.sv
module rx_wake_standby
  import rxw_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic rxEnable,
  input  logic loopMode,
  input  logic standbyWr,
  input  logic standbyWrVal,
  input  logic wakeSel,
  input  logic idleStrobe,
  input  logic charStrobe,
  input  logic charMsb,
  input  logic readyClr,
  input  logic idleClr,
  input  logic rxIntEn,
  input  logic idleIntEn,
  output logic standby,
  output logic dataReady,
  output logic idleFlag,
  output logic rxIrq,
  output logic idleIrq,
  output logic rxPinOwn
);
  rxwStrobes_t strobes;

  rxw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rxEnable     (rxEnable),
    .standbyWr    (standbyWr),
    .standbyWrVal (standbyWrVal),
    .wakeSel      (wakeSel),
    .idleStrobe   (idleStrobe),
    .charStrobe   (charStrobe),
    .charMsb      (charMsb),
    .standby      (standby),
    .strobes      (strobes)
  );

  rxw_flags u_flags (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .readyClr  (readyClr),
    .idleClr   (idleClr),
    .rxIntEn   (rxIntEn),
    .idleIntEn (idleIntEn),
    .dataReady (dataReady),
    .idleFlag  (idleFlag),
    .rxIrq     (rxIrq),
    .idleIrq   (idleIrq)
  );

  // Loop operation releases the pin even with the receiver on (R9).
  assign rxPinOwn = rxEnable && !loopMode;
endmodule

// File: rtl/rx_wake_standby_chk.sv
module rx_wake_standby_chk (
  input logic clk,
  input logic rstN,
  input logic rxEnable,
  input logic standbyWr,
  input logic standbyWrVal,
  input logic wakeSel,
  input logic idleStrobe,
  input logic charStrobe,
  input logic charMsb,
  input logic readyClr,
  input logic standby,
  input logic dataReady,
  input logic idleFlag
);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && standbyWr && standbyWrVal |=> standby);

  p_idle_wake_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && standby && !wakeSel && idleStrobe && !standbyWr && !idleFlag
    |=> !standby && !idleFlag);

  p_addr_wake_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && standby && wakeSel && charStrobe && charMsb && !standbyWr
    |=> !standby && dataReady);

  p_no_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && standby && charStrobe && !(wakeSel && charMsb) && !dataReady
    |=> !dataReady);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable && !standby && charStrobe && readyClr |=> dataReady);

  p_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !standby && !dataReady && !idleFlag);
endmodule

bind rx_wake_standby rx_wake_standby_chk u_chk (.*);

// File: tb/rx_wake_standby_bench.sv
module rx_wake_standby_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 0, loopMode = 0, standbyWr = 0, standbyWrVal = 0, wakeSel = 0;
  logic idleStrobe = 0, charStrobe = 0, charMsb = 0, readyClr = 0, idleClr = 0;
  logic rxIntEn = 0, idleIntEn = 0;
  logic standby, dataReady, idleFlag, rxIrq, idleIrq, rxPinOwn;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_wake_standby u_rx_wake_standby (.*);

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic quiet();
    standbyWr = 0; standbyWrVal = 0; idleStrobe = 0; charStrobe = 0;
    charMsb = 0; readyClr = 0; idleClr = 0;
  endtask

  // Inputs are set just after a falling edge; one rising edge later they are checked.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic flush();
    quiet(); rxEnable = 0; tick(); rxEnable = 1;
  endtask

  task automatic enterStandby(logic ws);
    quiet(); rxEnable = 1; wakeSel = ws; standbyWr = 1; standbyWrVal = 1; tick(); quiet();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 standby", standby, 0);
    check("R1 dataReady", dataReady, 0);
    check("R1 idleFlag", idleFlag, 0);
    check("R1 rxIrq", rxIrq, 0);
    check("R1 idleIrq", idleIrq, 0);
    rstN = 1;
    tick();

    // Exhaustive sweep: enable x wake method x start standby x strobe pattern.
    rxIntEn = 1; idleIntEn = 1;
    for (int en = 0; en < 2; en++)
      for (int ws = 0; ws < 2; ws++)
        for (int s0 = 0; s0 < 2; s0++)
          for (int pat = 0; pat < 8; pat++) begin
            logic is, cs, msb, wake, expS, expR, expI;
            string tag;
            is = pat[0]; cs = pat[1]; msb = pat[2];
            flush();
            if (s0 != 0) enterStandby(ws[0]);
            wakeSel = ws[0]; rxEnable = en[0];
            idleStrobe = is; charStrobe = cs; charMsb = msb;
            tick();
            if (en == 0) begin
              expS = 0; expR = 0; expI = 0; tag = "R8";
            end else begin
              wake = (s0 != 0) && ((ws != 0) ? (cs && msb) : is);
              expS = (s0 != 0) && !wake;
              expR = cs && ((s0 == 0) || ((ws != 0) && msb));
              expI = is && (s0 == 0);
              tag = (s0 != 0) ? "R3,R4,R5" : "R6";
            end
            check({tag, " standby"}, standby, expS);
            check({tag, " dataReady"}, dataReady, expR);
            check({tag, " idleFlag"}, idleFlag, expI);
            check("R7 rxIrq", rxIrq, expR);
            check("R7 idleIrq", idleIrq, expI);
            quiet();
          end

    // R2: leave standby by writing 0.
    flush(); enterStandby(0);
    check("R2 enter", standby, 1);
    standbyWr = 1; standbyWrVal = 0; tick(); quiet();
    check("R2 leave", standby, 0);

    // R3: after an idle wake, the next character is received normally.
    flush(); enterStandby(0);
    idleStrobe = 1; tick(); quiet();
    check("R3 woke", standby, 0);
    check("R3 no idle flag", idleFlag, 0);
    charStrobe = 1; tick(); quiet();
    check("R3 next char", dataReady, 1);

    // R6: clears, and set beats clear.
    readyClr = 1; tick(); quiet();
    check("R6 ready cleared", dataReady, 0);
    charStrobe = 1; readyClr = 1; tick(); quiet();
    check("R6 set wins", dataReady, 1);
    idleStrobe = 1; tick(); quiet();
    check("R6 idle set", idleFlag, 1);
    idleClr = 1; tick(); quiet();
    check("R6 idle cleared", idleFlag, 0);

    // R7: interrupt enables gate the flags.
    rxIntEn = 0; #1;
    check("R7 rx masked", rxIrq, 0);
    rxIntEn = 1; #1;
    check("R7 rx unmasked", rxIrq, 1);

    // R8: a write while disabled does nothing, even after re-enabling.
    quiet(); rxEnable = 0; standbyWr = 1; standbyWrVal = 1; tick(); quiet();
    check("R8 write ignored", standby, 0);
    rxEnable = 1; tick();
    check("R8 nothing latched", standby, 0);

    // R10: write and address-mark wake in one cycle.
    flush(); enterStandby(1);
    standbyWr = 1; standbyWrVal = 1; charStrobe = 1; charMsb = 1; tick(); quiet();
    check("R10 write wins", standby, 1);
    check("R10 char delivered", dataReady, 1);

    // R9: pin ownership over all enable/loop combinations.
    for (int k = 0; k < 4; k++) begin
      rxEnable = k[0]; loopMode = k[1]; #1;
      check("R9 pin owner", rxPinOwn, k[0] && !k[1]);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule